// File: doc/BRIEF.md
# Link Detect Substate Controller

This block runs the Detect phase of a serial link training state machine for a multi-lane port. After reset it sits in a quiet substate, in which the transmitters are idle. It stays there until either a 12 ms timeout expires or an assigned lane leaves electrical idle. It then moves to an active substate and asks the transceiver to run a receiver detection. If no assigned lane reports a receiver, the block goes back to the quiet substate and the quiet timing starts again from zero.

A 2-bit minimum-dwell setting stops a lane's idle exit from ending the quiet substate too early. This keeps detection attempts apart, so that the transmit lines have time to discharge between them. Lanes that are not assigned to the link are masked so that they always read as idle. When a detection finds at least one assigned lane, the block records which lanes it found, gives a one-cycle hand-off pulse toward the Polling state, and stays parked until reset.

All timing counts a free-running one-microsecond tick input. The receiver-detect interface is a plain request/done handshake. The request stays high for as long as the block is in the active substate. The transceiver may hold off done for any number of cycles. The result lanes are taken only in a cycle in which done is high.

Top module: `link_detect_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released: `substate` is 2'b00 (quiet), `rxdet_req` is 0, `to_polling` is 0 and `detected_lanes` is 0.
- R2: With every lane idle, the quiet substate ends after 12000 counted ticks. The count clears on every entry to quiet and advances only in cycles where `us_tick` is 1. With the tick high every cycle, the substate reads 2'b01 after the 12001st clock edge that follows the entry edge.
- R3: `min_dly_cfg` selects the minimum quiet dwell in ticks: 2'b00 = 0, 2'b01 = 100, 2'b10 = 1000, 2'b11 = 2000. An idle exit present from the entry onward ends quiet after edge (minimum + 1).
- R4: Once the minimum has elapsed, any assigned lane with `lane_idle` at 0 ends the quiet substate at the next clock edge.
- R5: A lane whose `lane_assign` bit is 0 is treated as idle. Its receiver result is ignored as well.
- R6: `rxdet_req` is 1 exactly while the substate is 2'b01 and stays high until `rxdet_done` is seen. `rxdet_done` outside the active substate has no effect.
- R7: A done with no assigned lane reporting a receiver returns the block to quiet at that edge, with the full quiet timing restarted.
- R8: A done with at least one assigned lane reporting a receiver loads `detected_lanes` with `rxdet_found & lane_assign`, sets `substate` to 2'b10 and raises `to_polling` for exactly one cycle. The block stays in 2'b10 until reset.
- R9: `min_dly_cfg` is sampled only on entry to quiet (the reset edge or the edge that returns from active). A change while in quiet takes effect on the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| lane_idle | input | LANES | Per-lane electrical-idle status, 1 = idle |
| lane_assign | input | LANES | Lanes belonging to this link, 1 = assigned |
| min_dly_cfg | input | 2 | Minimum quiet dwell code |
| rxdet_req | output | 1 | Receiver-detect request to the transceiver |
| rxdet_done | input | 1 | Receiver detection complete |
| rxdet_found | input | LANES | Per-lane receiver-present result, valid with done |
| substate | output | 2 | 00 quiet, 01 active, 10 passed to Polling |
| detected_lanes | output | LANES | Lanes on which a receiver was found |
| to_polling | output | 1 | One-cycle pulse on hand-off to Polling |

## Verification
Every result is registered, so it is visible one clock edge after the inputs that cause it. A done moves the substate and the detected-lane mask at that same edge. The exit from quiet shows one edge after the counted tick total reaches the limit. The bench drives inputs and compares all outputs at falling edges, against a behavioural model that updates at each rising edge. Dwell lengths are checked by counting the rising edges from the entry edge to the first falling edge at which the substate is no longer quiet. The expected counts are the tick limit plus one.

// File: rtl/ldet_pkg.sv
package ldet_pkg;
  typedef enum logic [1:0] {
    DS_QUIET  = 2'b00,
    DS_ACTIVE = 2'b01,
    DS_POLL   = 2'b10
  } ldet_state_e;
endpackage

// File: rtl/ldet_lane_gate.sv
module ldet_lane_gate #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] lane_idle,
  input  logic [LANES-1:0] lane_assign,
  input  logic [LANES-1:0] rx_found,
  output logic             wake,
  output logic [LANES-1:0] found_masked
);
  logic [LANES-1:0] active_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // an unassigned lane is forced to look idle
    assign active_lane[g]  = lane_assign[g] & ~lane_idle[g];
    assign found_masked[g] = lane_assign[g] & rx_found[g];
  end

  assign wake = |active_lane;
endmodule

// File: rtl/ldet_quiet_timer.sv
module ldet_quiet_timer #(
  parameter int TIMEOUT_TICKS = 12000,
  parameter int DLY1_TICKS    = 100,
  parameter int DLY2_TICKS    = 1000,
  parameter int DLY3_TICKS    = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] cfg_code,
  output logic       timed_out,
  output logic       min_met
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LIM_TO = CW'(TIMEOUT_TICKS);
  localparam logic [CW-1:0] LIM_1  = CW'(DLY1_TICKS);
  localparam logic [CW-1:0] LIM_2  = CW'(DLY2_TICKS);
  localparam logic [CW-1:0] LIM_3  = CW'(DLY3_TICKS);

  logic [CW-1:0] cnt_q;
  logic [1:0]    code_q;
  logic [CW-1:0] min_lim;

  always_comb begin
    case (code_q)
      2'b01:   min_lim = LIM_1;
      2'b10:   min_lim = LIM_2;
      2'b11:   min_lim = LIM_3;
      default: min_lim = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q  <= '0;
      code_q <= cfg_code;
    end else if (run && tick && (cnt_q < LIM_TO)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timed_out = (cnt_q >= LIM_TO);
  assign min_met   = (cnt_q >= min_lim);
endmodule

// File: rtl/link_detect_ctrl.sv
module link_detect_ctrl
  import ldet_pkg::*;
#(
  parameter int LANES         = 4,
  parameter int TIMEOUT_TICKS = 12000,
  parameter int DLY1_TICKS    = 100,
  parameter int DLY2_TICKS    = 1000,
  parameter int DLY3_TICKS    = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic [LANES-1:0] lane_idle,
  input  logic [LANES-1:0] lane_assign,
  input  logic [1:0]       min_dly_cfg,
  output logic             rxdet_req,
  input  logic             rxdet_done,
  input  logic [LANES-1:0] rxdet_found,
  output logic [1:0]       substate,
  output logic [LANES-1:0] detected_lanes,
  output logic             to_polling
);
  ldet_state_e      state_q;
  logic             wake;
  logic [LANES-1:0] found_m;
  logic             timed_out;
  logic             min_met;
  logic             any_found;
  logic             retry;
  logic             pass_q;
  logic [LANES-1:0] mask_q;

  ldet_lane_gate #(.LANES(LANES)) u_gate (
    .lane_idle    (lane_idle),
    .lane_assign  (lane_assign),
    .rx_found     (rxdet_found),
    .wake         (wake),
    .found_masked (found_m)
  );

  assign any_found = |found_m;
  assign retry     = (state_q == DS_ACTIVE) && rxdet_done && !any_found;

  ldet_quiet_timer #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .DLY1_TICKS    (DLY1_TICKS),
    .DLY2_TICKS    (DLY2_TICKS),
    .DLY3_TICKS    (DLY3_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (retry),
    .run       (state_q == DS_QUIET),
    .tick      (us_tick),
    .cfg_code  (min_dly_cfg),
    .timed_out (timed_out),
    .min_met   (min_met)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DS_QUIET;
      pass_q  <= 1'b0;
      mask_q  <= '0;
    end else begin
      pass_q <= 1'b0;
      case (state_q)
        DS_QUIET: begin
          if (timed_out || (wake && min_met)) state_q <= DS_ACTIVE;
        end
        DS_ACTIVE: begin
          if (rxdet_done) begin
            if (any_found) begin
              state_q <= DS_POLL;
              mask_q  <= found_m;
              pass_q  <= 1'b1;
            end else begin
              state_q <= DS_QUIET;
            end
          end
        end
        default: state_q <= DS_POLL;
      endcase
    end
  end

  assign rxdet_req      = (state_q == DS_ACTIVE);
  assign substate       = state_q;
  assign detected_lanes = mask_q;
  assign to_polling     = pass_q;
endmodule

// File: rtl/ldet_checker.sv
module ldet_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rxdet_req,
  input logic             rxdet_done,
  input logic [1:0]       substate,
  input logic [LANES-1:0] detected_lanes,
  input logic             to_polling
);
  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rxdet_req && !rxdet_done) |=> rxdet_req);

  p_active_waits_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (substate == 2'b01 && !rxdet_done) |=> (substate == 2'b01));

  p_quiet_never_polls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (substate == 2'b00) |=> (substate != 2'b10));

  p_pass_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    to_polling |=> !to_polling);

  p_poll_terminal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (substate == 2'b10) |=> (substate == 2'b10 && $stable(detected_lanes)));

  p_pass_has_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    to_polling |-> (substate == 2'b10 && detected_lanes != '0));
endmodule

bind link_detect_ctrl ldet_checker #(.LANES(LANES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rxdet_req      (rxdet_req),
  .rxdet_done     (rxdet_done),
  .substate       (substate),
  .detected_lanes (detected_lanes),
  .to_polling     (to_polling)
);

// File: tb/link_detect_ctrl_tb.sv
module link_detect_ctrl_tb;
  localparam int L  = 4;
  localparam int TO = 12000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         us_tick = 1'b1;
  logic [L-1:0] lane_idle = '1;
  logic [L-1:0] lane_assign = '1;
  logic [1:0]   min_dly_cfg = 2'b00;
  logic         rxdet_req;
  logic         rxdet_done = 1'b0;
  logic [L-1:0] rxdet_found = '0;
  logic [1:0]   substate;
  logic [L-1:0] detected_lanes;
  logic         to_polling;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  bit finished = 0;

  // behavioural reference
  int m_st = 0, m_cnt = 0, m_min = 0, m_mask = 0, m_pass = 0;

  always #4 clk = ~clk;

  link_detect_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .lane_idle(lane_idle),
    .lane_assign(lane_assign), .min_dly_cfg(min_dly_cfg), .rxdet_req(rxdet_req),
    .rxdet_done(rxdet_done), .rxdet_found(rxdet_found), .substate(substate),
    .detected_lanes(detected_lanes), .to_polling(to_polling)
  );

  function automatic int mdec(input logic [1:0] c);
    case (c)
      2'b01:   return 100;
      2'b10:   return 1000;
      2'b11:   return 2000;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string rq, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_min = mdec(min_dly_cfg); m_mask = 0; m_pass = 0;
    end else begin
      m_pass = 0;
      if (m_st == 0) begin
        if (m_cnt >= TO || ((|(lane_assign & ~lane_idle)) && m_cnt >= m_min)) m_st = 1;
        else if (us_tick) m_cnt++;
      end else if (m_st == 1) begin
        if (rxdet_done) begin
          if (|(rxdet_found & lane_assign)) begin
            m_st = 2; m_mask = int'(rxdet_found & lane_assign); m_pass = 1;
          end else begin
            m_st = 0; m_cnt = 0; m_min = mdec(min_dly_cfg);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R2", int'(substate), m_st, "model substate");
      chk("R6", int'(rxdet_req), (m_st == 1) ? 1 : 0, "model request");
      chk("R8", int'(detected_lanes), m_mask, "model lane mask");
      chk("R8", int'(to_polling), m_pass, "model pass pulse");
    end
  end

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  // counts rising edges until substate leaves quiet
  task automatic count_quiet(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (substate == 2'b00 && n < 20000);
  endtask

  // done with no receiver: returns to quiet at the next edge
  task automatic no_receiver();
    rxdet_found = '0; rxdet_done = 1'b1;
    @(negedge clk);
    rxdet_done = 1'b0;
    chk("R7", int'(substate), 0, "back to quiet after empty detect");
  endtask

  initial begin
    int n;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(substate), 0, "reset substate");
    chk("R1", int'(rxdet_req), 0, "reset request");
    chk("R1", int'(to_polling), 0, "reset pass");
    chk("R1", int'(detected_lanes), 0, "reset mask");
    rst_n = 1'b1;
    chk("R1", int'(substate), 0, "first cycle after reset");

    count_quiet(n);
    chk("R2", n, TO + 1, "timeout dwell edges");
    chk("R6", int'(rxdet_req), 1, "request in active");
    repeat (5) @(negedge clk);
    chk("R6", int'(rxdet_req), 1, "request held without done");

    lane_assign = 4'b0011; lane_idle = 4'b0111; min_dly_cfg = 2'b01;
    no_receiver();
    count_quiet(n);
    chk("R5", n, TO + 1, "unassigned lane exit ignored");

    lane_idle = 4'b1110;
    no_receiver();
    count_quiet(n);
    chk("R3", n, 101, "code 01 dwell");
    min_dly_cfg = 2'b10;
    no_receiver();
    count_quiet(n);
    chk("R3", n, 1001, "code 10 dwell");

    min_dly_cfg = 2'b11;
    no_receiver();
    min_dly_cfg = 2'b00;
    count_quiet(n);
    chk("R9", n, 2001, "mid-quiet config change deferred");
    no_receiver();
    count_quiet(n);
    chk("R9", n, 1, "new code 00 applied on entry");

    lane_idle = '1; min_dly_cfg = 2'b01;
    no_receiver();
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk("R4", int'(substate), 0, "still quiet without exit");
    lane_idle = 4'b1110;
    count_quiet(n);
    chk("R4", n, 1, "late exit leaves at next edge");

    us_tick = 1'b0;
    no_receiver();
    repeat (500) @(negedge clk);
    chk("R2", int'(substate), 0, "no ticks keeps quiet");
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      us_tick = i[0];
    end
    chk("R2", int'(substate), 1, "alternate ticks reach limit");
    us_tick = 1'b1;

    min_dly_cfg = 2'b11;
    no_receiver();
    rxdet_found = '1; rxdet_done = 1'b1;
    @(negedge clk);
    rxdet_done = 1'b0; rxdet_found = '0;
    @(negedge clk);
    chk("R6", int'(substate), 0, "done in quiet ignored");
    chk("R6", int'(to_polling), 0, "no pass from quiet done");
    chk("R6", int'(detected_lanes), 0, "mask untouched by quiet done");
    count_quiet(n);

    rxdet_found = 4'b1100; rxdet_done = 1'b1;
    @(negedge clk);
    rxdet_done = 1'b0;
    chk("R5", int'(substate), 0, "unassigned receivers ignored");
    min_dly_cfg = 2'b00;
    count_quiet(n);
    chk("R3", n, 2001, "code 11 dwell");
    no_receiver();
    count_quiet(n);
    chk("R3", n, 1, "code 00 dwell");

    rxdet_found = 4'b0110; rxdet_done = 1'b1;
    @(negedge clk);
    rxdet_done = 1'b0; rxdet_found = '0;
    chk("R8", int'(substate), 2, "passed substate");
    chk("R8", int'(to_polling), 1, "pass pulse");
    chk("R8", int'(detected_lanes), 2, "masked lanes 0010");
    @(negedge clk);
    chk("R8", int'(to_polling), 0, "pass lasts one cycle");
    rxdet_done = 1'b1; lane_idle = '1;
    @(negedge clk);
    rxdet_done = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8", int'(substate), 2, "terminal until reset");
    chk("R8", int'(detected_lanes), 2, "mask held");
    summary();
  end
endmodule